// File: doc/BRIEF.md
# 1-Wire Network Command Layer (Slave Side)

This block is the network-addressing stage of a 1-Wire slave. Below it sits a bit transport that recovers the slots. The transport gives the block a strobe for each bit the master writes and a request each time the master opens a read slot. It also flags a bus reset and reports whether the bus currently runs at the high rate. The block decodes the network command byte and plays out or compares its 64-bit identity. When the command succeeds it raises `selected`, which unlocks the memory command layer above it.

The identity is built from two parameters: an 8-bit family code and a 48-bit serial number. After reset a serial engine shifts these 56 bits through a CRC-8 register with polynomial x^8+x^5+x^4+1, starting from zero, and stores the result as the top byte of the identity. The engine then shifts the stored byte through the register as well and reports whether the residue is zero. Slots that arrive before this finishes are ignored.

Two flags are kept. The resume flag lets a device that was individually addressed be selected again with a one-byte command. The overdrive flag tells the transport to switch to the high rate. A standard-speed bus reset clears the overdrive flag.

Top module: `ow_netcmd`

## Requirements
- R1: While `rst_n` is low, `selected`, `od_en`, `id_ready` and `crc_ok` are 0 and `tx_bit` is 1.
- R2: `id_ready` rises 64 clock edges after reset release, with `crc_ok` = 1. Identity bits 56..63 hold the CRC-8 of bits 0..55 (polynomial x^8+x^5+x^4+1, register starting at 0, bit 0 first).
- R3: Write strobes and read requests that arrive while `id_ready` is 0 are ignored: a Skip byte sent then leaves `selected` at 0.
- R4: The command byte is taken least significant bit first from 8 write strobes. Codes: 33h Read, 55h Match, F0h Search, CCh Skip, A5h Resume, 3Ch Overdrive-Skip, 69h Overdrive-Match. Any other code deselects the device until the next bus reset: `selected` stays 0 and read slots return 1.
- R5: After Read (33h), 64 read slots return the identity with bit 0 first: family code 2Dh in bits 0..7, serial in bits 8..55, CRC in bits 56..63. `selected` rises on the last slot.
- R6: After Match (55h), 64 write strobes are compared with the identity, bit 0 first. If all of them agree, `selected` rises. On the first bit that differs the device drops out: `selected` stays 0 and later read slots return 1.
- R7: After Search (F0h), each identity bit takes three slots: a read slot that returns the bit, a read slot that returns its complement, and a write strobe carrying the master's direction. A direction that differs from the identity bit drops the device out. After 64 agreeing directions, `selected` rises.
- R8: Skip (CCh) raises `selected` on the edge that takes the eighth command bit.
- R9: The resume flag is set by a successful Match or Search. Read, Skip, Overdrive-Skip and a failed Match or Search clear it, and a bus reset leaves it alone. Resume (A5h) raises `selected` only when the flag is set; otherwise it deselects.
- R10: When `od_active` is 0, Overdrive-Skip and Overdrive-Match set `od_en` on the edge that takes the eighth command bit. Overdrive-Skip then selects at once, and Overdrive-Match goes on to a Match of the identity.
- R11: A bus reset clears `selected` and returns the layer to collecting a command byte. With `od_active` = 0 it clears `od_en`; with `od_active` = 1 it leaves `od_en` unchanged.
- R12: When `od_active` is 1, the overdrive commands behave as plain Skip and Match and do not change `od_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_reset | input | 1 | One-cycle pulse: the transport saw a reset pulse on the bus |
| od_active | input | 1 | The transport is currently at the high rate |
| rx_valid | input | 1 | One-cycle strobe: the master wrote a bit |
| rx_bit | input | 1 | Value of the written bit |
| tx_req | input | 1 | One-cycle request: the master opened a read slot |
| tx_bit | output | 1 | Bit to send in the requested read slot (1 releases the line) |
| selected | output | 1 | A network command completed; memory commands are unlocked |
| od_en | output | 1 | Request to the transport to run at the high rate |
| id_ready | output | 1 | Identity CRC generation and checking has finished |
| crc_ok | output | 1 | CRC residue of the full identity was zero |

## Verification
A wrong CRC byte or a bit-index slip in the identity shows up in the first Read slot that reaches the bad bit. A Match or Search against the true identity then fails: it never raises `selected` and returns 1 for the slots after the bit. A resume or overdrive flag left in the wrong state is invisible until the next bus reset. After that reset, a Resume byte selects or fails to select eight strobes later, and `od_en` shows the overdrive state on the edge after the reset pulse. A sequencer stuck in the wrong state usually shows as `selected` staying at 0, or as a read slot returning 1 where an identity bit was due.

// File: rtl/ow_netcmd_pkg.sv
package ow_netcmd_pkg;

  localparam int FAM_W  = 8;
  localparam int SER_W  = 48;
  localparam int CRC_W  = 8;
  localparam int BODY_W = FAM_W + SER_W;
  localparam int ID_W   = BODY_W + CRC_W;

  localparam logic [7:0] NC_READ     = 8'h33;
  localparam logic [7:0] NC_MATCH    = 8'h55;
  localparam logic [7:0] NC_SEARCH   = 8'hF0;
  localparam logic [7:0] NC_SKIP     = 8'hCC;
  localparam logic [7:0] NC_RESUME   = 8'hA5;
  localparam logic [7:0] NC_OD_SKIP  = 8'h3C;
  localparam logic [7:0] NC_OD_MATCH = 8'h69;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SRCH_ID,
    ST_SRCH_CMP,
    ST_SRCH_DIR,
    ST_SEL,
    ST_OFF
  } net_state_e;

  // One step of the reflected x^8+x^5+x^4+1 register (bit 0 is the output end).
  function automatic logic [CRC_W-1:0] crc8_step(input logic [CRC_W-1:0] crc,
                                                 input logic din);
    logic fb;
    fb = crc[0] ^ din;
    crc8_step = {1'b0, crc[CRC_W-1:1]} ^ ({CRC_W{fb}} & 8'h8C);
  endfunction

endpackage

// File: rtl/ow_crc_gen.sv
module ow_crc_gen
  import ow_netcmd_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h2D,
  parameter logic [SER_W-1:0] SERIAL_NO   = 48'h0001_A5C3_7E19
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [ID_W-1:0] id_word,
  output logic            id_ready,
  output logic            crc_ok
);

  localparam int PW = $clog2(ID_W + 1);
  localparam logic [BODY_W-1:0] BODY = {SERIAL_NO, FAMILY_CODE};

  logic [PW-1:0]    pos_q;
  logic [CRC_W-1:0] crc_q, crc_byte_q, crc_next;
  logic             ready_q, ok_q;
  logic             din;
  logic             in_body;

  assign in_body  = (pos_q < PW'(BODY_W));
  assign din      = in_body ? BODY[pos_q[5:0]] : crc_byte_q[pos_q[2:0]];
  assign crc_next = crc8_step(crc_q, din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q      <= '0;
      crc_q      <= '0;
      crc_byte_q <= '0;
      ready_q    <= 1'b0;
      ok_q       <= 1'b0;
    end else if (!ready_q) begin
      crc_q <= crc_next;
      pos_q <= pos_q + 1'b1;
      if (pos_q == PW'(BODY_W - 1)) crc_byte_q <= crc_next;
      if (pos_q == PW'(ID_W - 1)) begin
        ready_q <= 1'b1;
        ok_q    <= (crc_next == '0);
      end
    end
  end

  assign id_word  = {crc_byte_q, BODY};
  assign id_ready = ready_q;
  assign crc_ok   = ok_q;

  // R2: shifting the stored CRC behind the body must always cancel to zero.
  p_residue_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_ready) |-> crc_ok);

  p_ready_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    id_ready |=> id_ready && $stable(id_word));

endmodule

// File: rtl/ow_flags.sv
module ow_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic od_active,
  input  logic set_rf,
  input  logic clr_rf,
  input  logic set_od,
  output logic rf,
  output logic od_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf    <= 1'b0;
      od_en <= 1'b0;
    end else begin
      if (set_rf)      rf <= 1'b1;
      else if (clr_rf) rf <= 1'b0;

      if (bus_reset && !od_active) od_en <= 1'b0;
      else if (set_od)             od_en <= 1'b1;
    end
  end

  p_rf_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_rf && clr_rf));

  p_od_std_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !od_active) |=> !od_en);

  p_od_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && od_active) |=> $stable(od_en));

  // R12: at the high rate no command may raise the overdrive request.
  p_od_no_set_fast_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (od_active && !od_en) |=> !od_en);

endmodule

// File: rtl/ow_net_fsm.sv
module ow_net_fsm
  import ow_netcmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset,
  input  logic            od_active,
  input  logic            rx_valid,
  input  logic            rx_bit,
  input  logic            tx_req,
  input  logic            id_ready,
  input  logic [ID_W-1:0] id_word,
  input  logic            rf,
  output logic            tx_bit,
  output logic            selected,
  output logic            set_rf,
  output logic            clr_rf,
  output logic            set_od
);

  localparam int CNT_W = $clog2(ID_W);

  net_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [6:0]       sr_q, sr_d;
  logic [2:0]       ccnt_q, ccnt_d;

  logic       rx_ok, tx_ok, id_bit, last_bit;
  logic [7:0] cmd_byte;
  logic       ev_cmd_byte, ev_id_miss, ev_id_done;

  assign rx_ok    = rx_valid & id_ready;
  assign tx_ok    = tx_req & id_ready;
  assign id_bit   = id_word[cnt_q];
  assign last_bit = (cnt_q == CNT_W'(ID_W - 1));
  assign cmd_byte = {rx_bit, sr_q};

  assign ev_cmd_byte = (state_q == ST_CMD) && rx_ok && (ccnt_q == 3'd7);
  assign ev_id_miss  = rx_ok && (rx_bit != id_bit) &&
                       (state_q == ST_MATCH || state_q == ST_SRCH_DIR);
  assign ev_id_done  = rx_ok && (rx_bit == id_bit) && last_bit &&
                       (state_q == ST_MATCH || state_q == ST_SRCH_DIR);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sr_d    = sr_q;
    ccnt_d  = ccnt_q;
    set_rf  = 1'b0;
    clr_rf  = 1'b0;
    set_od  = 1'b0;
    if (bus_reset) begin
      state_d = ST_CMD;
      cnt_d   = '0;
      ccnt_d  = '0;
    end else begin
      unique case (state_q)
        ST_CMD: if (rx_ok) begin
          sr_d   = {rx_bit, sr_q[6:1]};
          ccnt_d = ccnt_q + 3'd1;
          cnt_d  = '0;
          if (ev_cmd_byte) begin
            unique case (cmd_byte)
              NC_READ:   begin state_d = ST_READ; clr_rf = 1'b1; end
              NC_MATCH:  state_d = ST_MATCH;
              NC_SEARCH: state_d = ST_SRCH_ID;
              NC_SKIP:   begin state_d = ST_SEL; clr_rf = 1'b1; end
              NC_RESUME: state_d = rf ? ST_SEL : ST_OFF;
              NC_OD_SKIP: begin
                state_d = ST_SEL;
                clr_rf  = 1'b1;
                set_od  = !od_active;
              end
              NC_OD_MATCH: begin
                state_d = ST_MATCH;
                set_od  = !od_active;
              end
              default: state_d = ST_OFF;
            endcase
          end
        end
        ST_READ: if (tx_ok) begin
          cnt_d = cnt_q + 1'b1;
          if (last_bit) state_d = ST_SEL;
        end
        ST_MATCH: if (rx_ok) begin
          cnt_d = cnt_q + 1'b1;
          if (ev_id_miss) begin
            state_d = ST_OFF;
            clr_rf  = 1'b1;
          end else if (last_bit) begin
            state_d = ST_SEL;
            set_rf  = 1'b1;
          end
        end
        ST_SRCH_ID:  if (tx_ok) state_d = ST_SRCH_CMP;
        ST_SRCH_CMP: if (tx_ok) state_d = ST_SRCH_DIR;
        ST_SRCH_DIR: if (rx_ok) begin
          cnt_d = cnt_q + 1'b1;
          if (ev_id_miss) begin
            state_d = ST_OFF;
            clr_rf  = 1'b1;
          end else if (last_bit) begin
            state_d = ST_SEL;
            set_rf  = 1'b1;
          end else begin
            state_d = ST_SRCH_ID;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
      sr_q    <= '0;
      ccnt_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sr_q    <= sr_d;
      ccnt_q  <= ccnt_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_READ, ST_SRCH_ID: tx_bit = id_bit;
      ST_SRCH_CMP:         tx_bit = ~id_bit;
      default:             tx_bit = 1'b1;
    endcase
  end

  assign selected = (state_q == ST_SEL);

  p_reset_desel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !selected);

  // R4: selection only ever follows a slot handed up by the transport.
  p_sel_from_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected) |-> $past(rx_valid || tx_req));

  p_not_ready_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !id_ready |-> (!selected && tx_bit));

  // R6 and R7: a disagreeing bit drops the device and releases the line.
  p_miss_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_id_miss && !bus_reset) |=> (!selected && tx_bit));

  p_done_selects_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_id_done && !bus_reset) |=> selected);

  p_byte_leaves_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd_byte && !bus_reset) |=> (state_q != ST_CMD));

endmodule

// File: rtl/ow_netcmd.sv
module ow_netcmd
  import ow_netcmd_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h2D,
  parameter logic [SER_W-1:0] SERIAL_NO   = 48'h0001_A5C3_7E19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic od_active,
  input  logic rx_valid,
  input  logic rx_bit,
  input  logic tx_req,
  output logic tx_bit,
  output logic selected,
  output logic od_en,
  output logic id_ready,
  output logic crc_ok
);

  logic [ID_W-1:0] id_word;
  logic            rf, set_rf, clr_rf, set_od;

  ow_crc_gen #(.FAMILY_CODE(FAMILY_CODE), .SERIAL_NO(SERIAL_NO)) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .id_word  (id_word),
    .id_ready (id_ready),
    .crc_ok   (crc_ok)
  );

  ow_net_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .od_active (od_active),
    .rx_valid  (rx_valid),
    .rx_bit    (rx_bit),
    .tx_req    (tx_req),
    .id_ready  (id_ready),
    .id_word   (id_word),
    .rf        (rf),
    .tx_bit    (tx_bit),
    .selected  (selected),
    .set_rf    (set_rf),
    .clr_rf    (clr_rf),
    .set_od    (set_od)
  );

  ow_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .od_active (od_active),
    .set_rf    (set_rf),
    .clr_rf    (clr_rf),
    .set_od    (set_od),
    .rf        (rf),
    .od_en     (od_en)
  );

endmodule

// File: tb/tb_ow_netcmd.sv
module tb_ow_netcmd;

  localparam int CLK_P = 10;
  localparam logic [7:0]  FAM = 8'h2D;
  localparam logic [47:0] SER = 48'h0001_A5C3_7E19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 1'b0, od_active = 1'b0;
  logic rx_valid = 1'b0, rx_bit = 1'b0, tx_req = 1'b0;
  logic tx_bit, selected, od_en, id_ready, crc_ok;

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;
  logic  exp_q[$];
  string req_q[$];
  logic [63:0] ident;

  always #(CLK_P/2) clk = ~clk;

  ow_netcmd dut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .od_active(od_active),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_req(tx_req), .tx_bit(tx_bit),
    .selected(selected), .od_en(od_en), .id_ready(id_ready), .crc_ok(crc_ok)
  );

  // Byte-at-a-time CRC over the 7 body bytes, bit 0 of each byte first.
  function automatic logic [7:0] body_crc(input logic [55:0] body);
    logic [7:0] c, b;
    c = 8'h00;
    for (int k = 0; k < 7; k++) begin
      b = body[k*8 +: 8];
      for (int j = 0; j < 8; j++) begin
        if ((c[0] ^ b[0]) == 1'b1) c = (c >> 1) ^ 8'h8C;
        else                       c = c >> 1;
        b = b >> 1;
      end
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_bit(input logic b);
    @(negedge clk); rx_bit = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wr_bit(v[i]);
  endtask

  // Driver side of the scoreboard: queue the expected bit, open a read slot.
  task automatic rd_bit(input logic e, input string req);
    exp_q.push_back(e);
    req_q.push_back(req);
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic bus_rst(input logic fast);
    @(negedge clk); od_active = fast; bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic match_id(input logic [63:0] v);
    for (int i = 0; i < 64; i++) wr_bit(v[i]);
  endtask

  task automatic search_id(input int bad);
    for (int i = 0; i < 64; i++) begin
      rd_bit(ident[i], "R7");
      rd_bit(~ident[i], "R7");
      if (i == bad) begin
        wr_bit(~ident[i]);
        return;
      end
      wr_bit(ident[i]);
    end
  endtask

  // Monitor side: sample the slot value late in the cycle the request is up.
  always @(posedge clk) begin
    #(3*CLK_P/4);
    if (tx_req) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected read slot", 64'(tx_bit), 64'h0);
      end else begin
        logic  e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(tx_bit === e, r, "read slot bit", 64'(tx_bit), 64'(e));
      end
    end
  end

  initial begin
    #(CLK_P*100000);
    if (!finished) begin
      check(1'b0, "R1", "watchdog expired", 64'h0, 64'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    ident = {body_crc({SER, FAM}), SER, FAM};
    repeat (3) @(negedge clk);
    // R1: reset state
    check(selected == 1'b0, "R1", "selected in reset", 64'(selected), 64'h0);
    check(od_en == 1'b0, "R1", "od_en in reset", 64'(od_en), 64'h0);
    check(id_ready == 1'b0 && crc_ok == 1'b0, "R1", "id flags in reset",
          64'({id_ready, crc_ok}), 64'h0);
    check(tx_bit == 1'b1, "R1", "tx_bit in reset", 64'(tx_bit), 64'h1);
    rst_n = 1'b1;

    // R3: a Skip byte before the identity is ready is dropped
    wr_byte(8'hCC);
    check(selected == 1'b0, "R3", "skip before ready", 64'(selected), 64'h0);
    check(id_ready == 1'b0, "R3", "still not ready", 64'(id_ready), 64'h0);
    repeat (60) @(negedge clk);
    check(id_ready == 1'b1, "R2", "id_ready", 64'(id_ready), 64'h1);
    check(crc_ok == 1'b1, "R2", "crc_ok", 64'(crc_ok), 64'h1);

    // R5 and R2: Read plays the identity including the CRC byte
    bus_rst(1'b0);
    wr_byte(8'h33);
    for (int i = 0; i < 64; i++) rd_bit(ident[i], i >= 56 ? "R2" : "R5");
    check(selected == 1'b1, "R5", "selected after read", 64'(selected), 64'h1);
    bus_rst(1'b0);
    check(selected == 1'b0, "R11", "bus reset deselects", 64'(selected), 64'h0);
    wr_byte(8'hA5);
    check(selected == 1'b0, "R9", "resume after read", 64'(selected), 64'h0);

    // R6: good match, then resume
    bus_rst(1'b0);
    wr_byte(8'h55);
    match_id(ident);
    check(selected == 1'b1, "R6", "match good", 64'(selected), 64'h1);
    bus_rst(1'b0);
    wr_byte(8'hA5);
    check(selected == 1'b1, "R9", "resume after match", 64'(selected), 64'h1);

    // R6: bad bit 10
    bus_rst(1'b0);
    wr_byte(8'h55);
    match_id(ident ^ (64'h1 << 10));
    check(selected == 1'b0, "R6", "match bad", 64'(selected), 64'h0);
    rd_bit(1'b1, "R6");
    bus_rst(1'b0);
    wr_byte(8'hA5);
    check(selected == 1'b0, "R9", "resume after failed match", 64'(selected), 64'h0);

    // R7: full search, then resume
    bus_rst(1'b0);
    wr_byte(8'hF0);
    search_id(-1);
    check(selected == 1'b1, "R7", "search good", 64'(selected), 64'h1);
    bus_rst(1'b0);
    wr_byte(8'hA5);
    check(selected == 1'b1, "R9", "resume after search", 64'(selected), 64'h1);

    // R7: wrong direction at bit 5
    bus_rst(1'b0);
    wr_byte(8'hF0);
    search_id(5);
    check(selected == 1'b0, "R7", "search dropped", 64'(selected), 64'h0);
    rd_bit(1'b1, "R7");

    // R8: skip
    bus_rst(1'b0);
    wr_byte(8'hCC);
    check(selected == 1'b1, "R8", "skip selects", 64'(selected), 64'h1);
    bus_rst(1'b0);
    wr_byte(8'hA5);
    check(selected == 1'b0, "R9", "resume after skip", 64'(selected), 64'h0);

    // R4: unknown code deselects until reset
    bus_rst(1'b0);
    wr_byte(8'h00);
    check(selected == 1'b0, "R4", "unknown code", 64'(selected), 64'h0);
    rd_bit(1'b1, "R4");
    wr_byte(8'hCC);
    check(selected == 1'b0, "R4", "skip after unknown", 64'(selected), 64'h0);

    // R10 and R11: overdrive skip
    bus_rst(1'b0);
    wr_byte(8'h3C);
    check(od_en == 1'b1 && selected == 1'b1, "R10", "od skip",
          64'({od_en, selected}), 64'h3);
    bus_rst(1'b1);
    check(od_en == 1'b1 && selected == 1'b0, "R11", "fast reset keeps od",
          64'({od_en, selected}), 64'h2);
    bus_rst(1'b0);
    check(od_en == 1'b0, "R11", "std reset clears od", 64'(od_en), 64'h0);

    // R10: overdrive match
    bus_rst(1'b0);
    wr_byte(8'h69);
    check(od_en == 1'b1 && selected == 1'b0, "R10", "od match byte",
          64'({od_en, selected}), 64'h2);
    od_active = 1'b1;
    match_id(ident);
    check(selected == 1'b1, "R10", "od match id", 64'(selected), 64'h1);
    bus_rst(1'b1);
    wr_byte(8'h3C);
    check(selected == 1'b1 && od_en == 1'b1, "R12", "od skip at fast",
          64'({od_en, selected}), 64'h3);
    bus_rst(1'b1);
    wr_byte(8'hA5);
    check(selected == 1'b0, "R9", "resume after od skip", 64'(selected), 64'h0);
    bus_rst(1'b0);
    check(od_en == 1'b0, "R11", "std reset clears od again", 64'(od_en), 64'h0);

    // R12: overdrive command at the high rate leaves od_en alone
    bus_rst(1'b1);
    wr_byte(8'h3C);
    check(selected == 1'b1 && od_en == 1'b0, "R12", "od skip no od set",
          64'({od_en, selected}), 64'h1);

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R5", "scoreboard drained", 64'(exp_q.size()), 64'h0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule